// File: doc/BRIEF.md
# Machine-Mode External Interrupt Trap Unit

This block sits next to a simple 32-bit in-order core. It owns the machine status, pending, cause, trap-vector and exception-PC registers. It decides on its own when an external interrupt request is turned into a trap. The core reaches those registers through a small CSR read/write port. The core also feeds in the PC of the instruction in flight and a one-cycle strobe for the machine return instruction. The unit answers with a redirect request and a target PC that the core applies to its fetch stage.

A trap is taken only on the cycle in which the pending bit is about to go from clear to set. This means a request held high produces exactly one entry. On entry the unit records the interrupted PC, writes a cause value that has only the interrupt flag set, and redirects to the trap vector with its low two bits masked. Trap entry does not change the global enable. On return the unit redirects to the saved PC, sets the global enable again if the previous-enable bit was set, and then forces the previous-enable bit to one.

Top module: `mirq_trap_unit`

## Requirements
- R1: After reset all five registers read as zero and `redirect_o` is low.
- R2: While `irq_req_i` is high and the enable bit (status bit 3) is clear, there is no redirect and the pending bit stays as it was. The trap is taken in the first cycle after software sets the enable bit.
- R3: Entry happens in a cycle with `irq_req_i` high, the enable bit set, the pending bit (bit 11 of the pending register) clear and no return strobe. In that cycle `redirect_o` is high and `redirect_pc_o` equals the trap-vector value with bits 1:0 forced to zero. On the next cycle the pending bit is set, the cause register reads 0x80000000 and the exception-PC register holds that cycle's `pc_i`.
- R4: While the pending bit is set, no new entry is taken, even with the request still high.
- R5: A cycle with `irq_req_i` low clears the pending bit on the next cycle.
- R6: With `mret_i` high, `redirect_o` is high in the same cycle and `redirect_pc_o` equals the exception-PC register. On the next cycle the enable bit becomes (enable OR previous-enable) and the previous-enable bit (status bit 7) reads one.
- R7: If `mret_i` and an otherwise valid entry fall in the same cycle, the return is served and entry waits for the following cycle.
- R8: A CSR write that falls in a cycle with an entry or a return is dropped entirely.
- R9: CSR map: status at 0x300 (only bits 3 and 7 are stored, all other bits read zero), trap vector at 0x305, exception PC at 0x341 and cause at 0x342 (all three full width), pending at 0x344 (read-only, only bit 11). Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| irq_req_i | input | 1 | Level-sensitive synchronous external interrupt request |
| pc_i | input | XLEN | PC of the instruction that an entry would interrupt |
| mret_i | input | 1 | One-cycle strobe for the machine return instruction |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Combinational CSR read data |
| redirect_o | output | 1 | Fetch redirect request (entry or return) |
| redirect_pc_o | output | XLEN | Redirect target PC |

## Verification
The bench builds the unit with its default 32-bit data path. It sweeps all 32 combinations of request level, enable, previous-enable, prior pending state and return strobe. Every combination carries a competing CSR write to the cause register, so the entry decision, the return priority and the write-drop rule are all checked against arithmetic predictions in one pass. Directed sequences then cover the deferred trap, the read masks of the CSR map and a trap-vector write lost to a return.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_STATUS = 12'h300;
  localparam logic [CSR_AW-1:0] ADDR_TVEC   = 12'h305;
  localparam logic [CSR_AW-1:0] ADDR_EPC    = 12'h341;
  localparam logic [CSR_AW-1:0] ADDR_CAUSE  = 12'h342;
  localparam logic [CSR_AW-1:0] ADDR_PEND   = 12'h344;

  localparam int BIT_IE   = 3;
  localparam int BIT_PIE  = 7;
  localparam int BIT_PEND = 11;
endpackage

// File: rtl/mirq_trap_ctrl.sv
module mirq_trap_ctrl #(
  parameter int XLEN = 32
) (
  input  logic            irq_req_i,
  input  logic            mret_i,
  input  logic            ie_i,
  input  logic            pend_i,
  input  logic [XLEN-1:0] tvec_i,
  input  logic [XLEN-1:0] epc_i,
  output logic            take_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  logic [XLEN-1:0] vec_base;

  always_comb begin
    vec_base      = {tvec_i[XLEN-1:2], 2'b00};
    // return has priority; a blocked entry retries next cycle
    take_o        = irq_req_i & ie_i & ~pend_i & ~mret_i;
    redirect_o    = take_o | mret_i;
    redirect_pc_o = mret_i ? epc_i : vec_base;
  end
endmodule

// File: rtl/mirq_csr_file.sv
module mirq_csr_file
  import mirq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              mret_i,
  input  logic              irq_req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              we_i,
  input  logic [CSR_AW-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              ie_o,
  output logic              pie_o,
  output logic              pend_o,
  output logic [XLEN-1:0]   tvec_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o
);
  localparam logic [XLEN-1:0] CAUSE_IRQ = {1'b1, {(XLEN-1){1'b0}}};

  logic            ie_q, pie_q, pend_q;
  logic            ie_d, pie_d, pend_d;
  logic [XLEN-1:0] tvec_q, epc_q, cause_q;
  logic [XLEN-1:0] tvec_d, epc_d, cause_d;
  logic            status_en, pend_en, tvec_en, epc_en, cause_en;
  logic            wr_ok;

  always_comb begin
    wr_ok     = we_i & ~take_i & ~mret_i;
    ie_d      = ie_q;
    pie_d     = pie_q;
    tvec_d    = wdata_i;
    epc_d     = wdata_i;
    cause_d   = wdata_i;
    status_en = 1'b0;
    tvec_en   = 1'b0;
    epc_en    = 1'b0;
    cause_en  = 1'b0;
    if (wr_ok) begin
      unique case (addr_i)
        ADDR_STATUS: begin
          ie_d      = wdata_i[BIT_IE];
          pie_d     = wdata_i[BIT_PIE];
          status_en = 1'b1;
        end
        ADDR_TVEC:  tvec_en  = 1'b1;
        ADDR_EPC:   epc_en   = 1'b1;
        ADDR_CAUSE: cause_en = 1'b1;
        default: ;
      endcase
    end
    if (mret_i) begin
      ie_d      = ie_q | pie_q;
      pie_d     = 1'b1;
      status_en = 1'b1;
    end
    if (take_i) begin
      epc_d    = pc_i;
      cause_d  = CAUSE_IRQ;
      epc_en   = 1'b1;
      cause_en = 1'b1;
    end
    pend_d  = irq_req_i & (pend_q | take_i);
    pend_en = ~irq_req_i | take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      pie_q <= 1'b0;
    end else if (status_en) begin
      ie_q  <= ie_d;
      pie_q <= pie_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tvec_q <= '0;
    else if (tvec_en) tvec_q <= tvec_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STATUS: begin
        rdata_o[BIT_IE]  = ie_q;
        rdata_o[BIT_PIE] = pie_q;
      end
      ADDR_PEND:  rdata_o[BIT_PEND] = pend_q;
      ADDR_TVEC:  rdata_o = tvec_q;
      ADDR_EPC:   rdata_o = epc_q;
      ADDR_CAUSE: rdata_o = cause_q;
      default: ;
    endcase
  end

  assign ie_o    = ie_q;
  assign pie_o   = pie_q;
  assign pend_o  = pend_q;
  assign tvec_o  = tvec_q;
  assign epc_o   = epc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/mirq_trap_unit.sv
module mirq_trap_unit
  import mirq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              mret_i,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o
);
  logic            take;
  logic            ie_q, pie_q, pend_q;
  logic [XLEN-1:0] tvec_q, epc_q, cause_q;

  mirq_trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .irq_req_i     (irq_req_i),
    .mret_i        (mret_i),
    .ie_i          (ie_q),
    .pend_i        (pend_q),
    .tvec_i        (tvec_q),
    .epc_i         (epc_q),
    .take_o        (take),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  mirq_csr_file #(.XLEN(XLEN)) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .mret_i    (mret_i),
    .irq_req_i (irq_req_i),
    .pc_i      (pc_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .wdata_i   (csr_wdata_i),
    .rdata_o   (csr_rdata_o),
    .ie_o      (ie_q),
    .pie_o     (pie_q),
    .pend_o    (pend_q),
    .tvec_o    (tvec_q),
    .epc_o     (epc_q),
    .cause_o   (cause_q)
  );
endmodule

// File: rtl/mirq_trap_checker.sv
module mirq_trap_checker #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_req_i,
  input logic [XLEN-1:0] pc_i,
  input logic            mret_i,
  input logic            csr_we_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            take,
  input logic            ie_q,
  input logic            pie_q,
  input logic            pend_q,
  input logic [XLEN-1:0] tvec_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] cause_q
);
  localparam logic [XLEN-1:0] CAUSE_IRQ = {1'b1, {(XLEN-1){1'b0}}};

  p_defer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !ie_q && !mret_i) |-> !redirect_o);

  p_entry_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (pend_q && cause_q == CAUSE_IRQ && epc_q == $past(pc_i)));

  p_entry_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> (redirect_o && redirect_pc_o[1:0] == 2'b00 &&
              redirect_pc_o[XLEN-1:2] == tvec_q[XLEN-1:2]));

  p_no_reentry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !take);

  p_pend_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_i |=> !pend_q);

  p_ret_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i |-> (redirect_o && redirect_pc_o == epc_q));

  p_ret_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i |=> (pie_q && ie_q == ($past(ie_q) || $past(pie_q))));

  p_ret_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i |-> !take);

  p_write_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && (take || mret_i)) |=> $stable(tvec_q));
endmodule

bind mirq_trap_unit mirq_trap_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mirq_trap_unit_tb.sv
`timescale 1ns/1ps
module mirq_trap_unit_tb;
  localparam int XLEN = 32;
  localparam logic [11:0] A_ST = 12'h300, A_TV = 12'h305, A_EPC = 12'h341,
                          A_CA = 12'h342, A_PD = 12'h344;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            irq, mret, we;
  logic [11:0]     addr;
  logic [XLEN-1:0] pc, wdata, rdata, rpc;
  logic            redir;
  int              n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  mirq_trap_unit #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .pc_i(pc), .mret_i(mret),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .redirect_o(redir), .redirect_pc_o(rpc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = 1'b0; mret = 1'b0; we = 1'b0;
    addr = '0; pc = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 redirect", {31'd0, redir}, 32'd0);
    rdchk("R1 status", A_ST, 0);
    rdchk("R1 tvec", A_TV, 0);
    rdchk("R1 epc", A_EPC, 0);
    rdchk("R1 cause", A_CA, 0);
    rdchk("R1 pend", A_PD, 0);

    // R9 map
    wr(A_ST, 32'hFFFF_FFFF);
    rdchk("R9 status mask", A_ST, 32'h88);
    wr(A_PD, 32'hFFFF_FFFF);
    rdchk("R9 pend read-only", A_PD, 0);
    wr(12'h7C0, 32'hDEAD_BEEF);
    rdchk("R9 unmapped", 12'h7C0, 0);
    wr(A_TV, 32'h0000_8003);
    rdchk("R9 tvec", A_TV, 32'h0000_8003);
    wr(A_ST, 0);
    rdchk("R9 status clear", A_ST, 0);

    // R2 deferral, then entry once enabled
    irq = 1'b1; pc = 32'h0000_1230;
    for (int i = 0; i < 4; i++) begin
      #0.5;
      chk("R2 deferred redirect", {31'd0, redir}, 0);
      rdchk("R2 pend unchanged", A_PD, 0);
      step();
    end
    wr(A_ST, 32'h8);
    #0.5;
    chk("R2 entry after enable", {31'd0, redir}, 1);
    chk("R3 vector target", rpc, 32'h0000_8000);
    step();
    rdchk("R3 pend set", A_PD, 32'h800);
    rdchk("R3 cause", A_CA, 32'h8000_0000);
    rdchk("R3 epc", A_EPC, 32'h0000_1230);
    #0.5;
    chk("R4 held request no reentry", {31'd0, redir}, 0);
    irq = 1'b0;
    step();
    rdchk("R5 pend cleared", A_PD, 0);

    // R8 trap-vector write lost to a return
    mret = 1'b1; we = 1'b1; addr = A_TV; wdata = 32'h0000_1234;
    step();
    mret = 1'b0; we = 1'b0;
    rdchk("R8 tvec write dropped", A_TV, 32'h0000_8003);

    // sweep: {irq, ie, pie, pend, mret}
    for (int idx = 0; idx < 32; idx++) begin
      logic t_irq, t_ie, t_pie, t_pend, t_ret, e_take;
      logic [31:0] e_epc, e_ca, p_pc;
      {t_irq, t_ie, t_pie, t_pend, t_ret} = idx[4:0];
      e_epc = 32'h2000_0000 + idx * 4;
      e_ca  = 32'h0000_0100 + idx;
      p_pc  = 32'h4000_0000 + idx * 16;
      if (t_pend) begin
        irq = 1'b1;
        wr(A_ST, 32'h8);
        step();
      end else begin
        irq = 1'b0;
        step();
      end
      wr(A_ST, {24'd0, t_pie, 3'd0, t_ie, 3'd0});
      wr(A_EPC, e_epc);
      wr(A_CA, e_ca);
      rdchk("R4/R5 setup pend", A_PD, {20'd0, t_pend, 11'd0});
      irq = t_irq; mret = t_ret; pc = p_pc;
      we = 1'b1; addr = A_CA; wdata = 32'h77;
      #0.5;
      e_take = t_irq & t_ie & ~t_pend & ~t_ret;
      chk("R3/R6/R7 redirect", {31'd0, redir}, {31'd0, e_take | t_ret});
      if (t_ret)       chk("R6 return target", rpc, e_epc);
      else if (e_take) chk("R3 entry target", rpc, 32'h0000_8000);
      step();
      we = 1'b0; mret = 1'b0;
      rdchk("R3/R4/R5 pend next", A_PD, {20'd0, t_irq & (t_pend | e_take), 11'd0});
      rdchk("R6 status next", A_ST,
            {24'd0, t_pie | t_ret, 3'd0, t_ie | (t_ret & t_pie), 3'd0});
      rdchk("R3/R8 cause next", A_CA,
            e_take ? 32'h8000_0000 : (t_ret ? e_ca : 32'h77));
      rdchk("R3/R7 epc next", A_EPC, e_take ? p_pc : e_epc);
      if (t_ret && t_irq && t_ie && !t_pend) begin
        #0.5;
        chk("R7 deferred entry follows", {31'd0, redir}, 1);
        step();
        rdchk("R7 epc after deferred entry", A_EPC, p_pc);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule